// File: doc/BRIEF.md
# Configurable Pseudo-Random Pattern Generator

This block produces a pseudo-random sequence of n-bit patterns for built-in self-test stimulus. Its feedback polynomial is fixed at elaboration by a coefficient vector. The polynomial always includes the constant term and the x^n term, so only the middle coefficients h1 to hn-1 are supplied.

A parameter selects one of two structures built from the same coefficient vector:

- **External-XOR form:** the parity of the tapped stages re-enters the top stage, and every stage shifts down by one.
- **Internal-XOR form:** the top stage re-enters stage 0 and is also XORed into each tapped stage as the bits move up.

A seed can be loaded at any time. The loaded value becomes the reference for a one-cycle wrap flag, which marks that the sequence has come back to its seed. A request to load all zeros is replaced by the value 1, because the all-zero state would lock the register.

Top module: `lfsr_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, `state` equals the RESET_SEED parameter (default 1) and `wrap` is 0.
- R2: In the external form, a step gives state[i] <= state[i+1] for i < n-1. It also gives state[n-1] <= state[0] XOR the XOR of state[i] over every i where TAPS[i]=1. For n=3 with TAPS=3'b010 and start value 1, the state values read as integers (bit i = stage i) run 4, 2, 5, 6, 7, 3, 1.
- R3: In the internal form, a step gives state[0] <= state[n-1], and state[i] <= state[i-1] XOR (TAPS[i] AND state[n-1]) for i >= 1. For n=3 with TAPS=3'b010 and start value 1, the state values run 2, 4, 3, 6, 7, 5, 1.
- R4: TAPS bit i is the coefficient of x^i for i from 1 to n-1, and bit 0 must be 0. With n=8 and TAPS=8'b0001_1100 (x^8+x^4+x^3+x^2+1), both forms first return to their start value after exactly 255 steps.
- R5: When `en` and `load` are both low, `state` keeps its value and `wrap` is 0.
- R6: `load` takes priority over `en`. On the next cycle `state` equals `seed`, and that value is stored as the wrap reference.
- R7: A load with `seed` equal to zero gives `state` equal to 1 on the next cycle.
- R8: `wrap` is 1 for exactly one cycle. That cycle is the one in which a step has just made `state` equal to the stored reference. A load never raises `wrap`.
- R9: `state` is never all zeros after reset.
- R10: With a primitive polynomial, over a full period the longest run of ones in state[0] is n and the longest run of zeros is n-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance the sequence by one step |
| load | input | 1 | Load `seed` into the state and the wrap reference |
| seed | input | WIDTH | Seed value; zero is replaced by 1 |
| state | output | WIDTH | Current pattern, bit i is stage i |
| wrap | output | 1 | One-cycle pulse when a step returns the state to the reference |

## Verification
The assertions check the following on every cycle:
- the shift relation between consecutive states for the selected form;
- the hold when idle;
- the load and zero-seed substitution;
- that the state is never zero;
- that `wrap` only appears while the state matches the reference.

Only the bench's scenarios can show:
- the exact n=3 sequences for both forms;
- the 255-step period of the 8-bit primitive polynomial in both structures;
- the run-length property;
- that `wrap` fires once per period and not at any earlier state.

// File: rtl/lfsr_gen_pkg.sv
package lfsr_gen_pkg;
   typedef enum logic {
      FB_EXTERNAL = 1'b0,
      FB_INTERNAL = 1'b1
   } fb_form_e;
endpackage

// File: rtl/lfsr_step_ext.sv
module lfsr_step_ext #(
   parameter int                 WIDTH = 8,
   parameter logic [WIDTH-1:0]   TAPS  = 8'b0001_1100
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);
   logic [WIDTH-1:0] tapped;

   // stage 0 always contributes (constant term of the polynomial)
   assign tapped[0] = cur[0];

   genvar gi;
   generate
      for (gi = 1; gi < WIDTH; gi++) begin : g_tap
         if (TAPS[gi]) begin : g_on
            assign tapped[gi] = cur[gi];
         end else begin : g_off
            assign tapped[gi] = 1'b0;
         end
      end
      for (gi = 0; gi < WIDTH-1; gi++) begin : g_shift
         assign nxt[gi] = cur[gi+1];
      end
   endgenerate

   assign nxt[WIDTH-1] = ^tapped;
endmodule

// File: rtl/lfsr_step_int.sv
module lfsr_step_int #(
   parameter int                 WIDTH = 8,
   parameter logic [WIDTH-1:0]   TAPS  = 8'b0001_1100
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);
   logic fb;
   assign fb     = cur[WIDTH-1];
   assign nxt[0] = fb;

   genvar gi;
   generate
      for (gi = 1; gi < WIDTH; gi++) begin : g_stage
         if (TAPS[gi]) begin : g_xor
            assign nxt[gi] = cur[gi-1] ^ fb;
         end else begin : g_pass
            assign nxt[gi] = cur[gi-1];
         end
      end
   endgenerate
endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg #(
   parameter int               WIDTH      = 8,
   parameter logic [WIDTH-1:0] RESET_SEED = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic [WIDTH-1:0] seed_in,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] state,
   output logic             wrap
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] ref_q;
   logic [WIDTH-1:0] seed_safe;

   assign seed_safe = (seed_in == '0) ? ONE : seed_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= RESET_SEED;
         ref_q <= RESET_SEED;
         wrap  <= 1'b0;
      end else if (load) begin
         state <= seed_safe;
         ref_q <= seed_safe;
         wrap  <= 1'b0;
      end else if (en) begin
         state <= nxt;
         wrap  <= (nxt == ref_q);
      end else begin
         wrap  <= 1'b0;
      end
   end

   // R5
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> ($stable(state) && !wrap));
   // R6
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && seed_in != '0) |=> (state == $past(seed_in)));
   // R7
   zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && seed_in == '0) |=> (state == ONE));
   // R8
   wrap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |-> (state == ref_q && $past(en) && !$past(load)));
   // R8
   wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !en) |=> !wrap);
   // R9
   nonzero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);
endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen
   import lfsr_gen_pkg::*;
#(
   parameter int                 WIDTH      = 8,
   parameter logic [WIDTH-1:0]   TAPS       = 8'b0001_1100,
   parameter fb_form_e           FORM       = FB_INTERNAL,
   parameter logic [WIDTH-1:0]   RESET_SEED = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic [WIDTH-1:0] seed,
   output logic [WIDTH-1:0] state,
   output logic             wrap
);
   localparam int TOP = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("lfsr_gen: WIDTH must be at least 2");
      end
      if (TAPS[0] != 1'b0) begin : g_bad_taps
         $error("lfsr_gen: TAPS bit 0 must be 0");
      end
      if (RESET_SEED == '0) begin : g_bad_seed
         $error("lfsr_gen: RESET_SEED must be nonzero");
      end
   endgenerate

   logic [WIDTH-1:0] nxt;

   generate
      if (FORM == FB_INTERNAL) begin : g_int
         lfsr_step_int #(.WIDTH(WIDTH), .TAPS(TAPS)) i_step (
            .cur(state), .nxt(nxt));

         // R3
         int_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !load) |=> (state[0] == $past(state[TOP])));
      end else begin : g_ext
         lfsr_step_ext #(.WIDTH(WIDTH), .TAPS(TAPS)) i_step (
            .cur(state), .nxt(nxt));

         // R2
         ext_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !load) |=> (state[TOP-1:0] == $past(state[TOP:1])));
      end
   endgenerate

   lfsr_state_reg #(.WIDTH(WIDTH), .RESET_SEED(RESET_SEED)) i_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .load    (load),
      .seed_in (seed),
      .nxt     (nxt),
      .state   (state),
      .wrap    (wrap)
   );

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (state == RESET_SEED && !wrap));
endmodule

// File: tb/test_lfsr_gen.sv
`timescale 1ns/1ps
module test_lfsr_gen;
   import lfsr_gen_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       en3 = 0, load3 = 0;
   logic [2:0] seed3 = 0;
   logic       en8 = 0, load8 = 0;
   logic [7:0] seed8 = 0;

   logic [2:0] st_e3, st_i3;
   logic       wr_e3, wr_i3;
   logic [7:0] st_i8, st_e8;
   logic       wr_i8, wr_e8;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   lfsr_gen i_lfsr_gen (
      .clk(clk), .rst_n(rst_n), .en(en8), .load(load8), .seed(seed8),
      .state(st_i8), .wrap(wr_i8));

   lfsr_gen #(.WIDTH(8), .TAPS(8'b0001_1100), .FORM(FB_EXTERNAL)) i_lfsr_gen_e8 (
      .clk(clk), .rst_n(rst_n), .en(en8), .load(load8), .seed(seed8),
      .state(st_e8), .wrap(wr_e8));

   lfsr_gen #(.WIDTH(3), .TAPS(3'b010), .FORM(FB_EXTERNAL)) i_lfsr_gen_e3 (
      .clk(clk), .rst_n(rst_n), .en(en3), .load(load3), .seed(seed3),
      .state(st_e3), .wrap(wr_e3));

   lfsr_gen #(.WIDTH(3), .TAPS(3'b010), .FORM(FB_INTERNAL)) i_lfsr_gen_i3 (
      .clk(clk), .rst_n(rst_n), .en(en3), .load(load3), .seed(seed3),
      .state(st_i3), .wrap(wr_i3));

   // {external state, internal state, wrap} after each step from state 1
   localparam logic [6:0] SEQ3 [7] = '{
      {3'd4, 3'd2, 1'b0},
      {3'd2, 3'd4, 1'b0},
      {3'd5, 3'd3, 1'b0},
      {3'd6, 3'd6, 1'b0},
      {3'd7, 3'd7, 1'b0},
      {3'd3, 3'd5, 1'b0},
      {3'd1, 3'd1, 1'b1}
   };
   // after loading 5: external then internal sequences
   localparam logic [5:0] SEQ5 [7] = '{
      {3'd6, 3'd1}, {3'd7, 3'd2}, {3'd3, 3'd4}, {3'd1, 3'd3},
      {3'd4, 3'd6}, {3'd2, 3'd7}, {3'd5, 3'd5}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int w8i, w8e, first_i, first_e, zero_seen;
      int run1_i, run0_i, max1_i, max0_i;
      int run1_e, run0_e, max1_e, max0_e;
      int wc;

      // R1 reset state
      repeat (3) @(negedge clk);
      check(st_e3 == 3'd1 && st_i3 == 3'd1, "R1 3-bit reset", st_e3, 1);
      check(st_i8 == 8'd1 && st_e8 == 8'd1, "R1 8-bit reset", st_i8, 1);
      check(!wr_e3 && !wr_i3 && !wr_i8 && !wr_e8, "R1 wrap low", wr_e3, 0);
      rst_n = 1'b1;
      tick();
      check(st_e3 == 3'd1 && !wr_e3, "R1 after release", st_e3, 1);

      // R2 R3 R8 table walk
      en3 = 1'b1;
      for (int k = 0; k < 7; k++) begin
         tick();
         check(st_e3 == SEQ3[k][6:4], "R2 external step", st_e3, SEQ3[k][6:4]);
         check(st_i3 == SEQ3[k][3:1], "R3 internal step", st_i3, SEQ3[k][3:1]);
         check(wr_e3 == SEQ3[k][0] && wr_i3 == SEQ3[k][0], "R8 wrap in table",
               wr_e3, SEQ3[k][0]);
      end

      // R5 hold
      en3 = 1'b0;
      tick();
      check(st_e3 == 3'd1 && st_i3 == 3'd1, "R5 hold state", st_e3, 1);
      check(!wr_e3 && !wr_i3, "R8 pulse ends / R5", wr_e3, 0);
      tick();
      check(st_e3 == 3'd1 && st_i3 == 3'd1, "R5 hold second cycle", st_i3, 1);

      // R6 load with priority over en
      en3 = 1'b1; load3 = 1'b1; seed3 = 3'd5;
      tick();
      load3 = 1'b0;
      check(st_e3 == 3'd5 && st_i3 == 3'd5, "R6 load value", st_e3, 5);
      check(!wr_e3 && !wr_i3, "R8 no wrap on load", wr_e3, 0);
      wc = 0;
      for (int k = 0; k < 7; k++) begin
         tick();
         check(st_e3 == SEQ5[k][5:3] && st_i3 == SEQ5[k][2:0], "R6 sequence from seed",
               st_e3, SEQ5[k][5:3]);
         if (wr_e3) wc++;
         check(wr_e3 == (k == 6) && wr_i3 == (k == 6), "R8 wrap against stored seed",
               wr_e3, (k == 6));
      end
      check(wc == 1, "R8 one wrap per period", wc, 1);

      // R7 zero seed
      load3 = 1'b1; seed3 = 3'd0;
      tick();
      load3 = 1'b0; en3 = 1'b0;
      check(st_e3 == 3'd1 && st_i3 == 3'd1, "R7 zero seed gives 1", st_i3, 1);

      // R4 R9 R10 8-bit period and runs
      w8i = 0; w8e = 0; first_i = 0; first_e = 0; zero_seen = 0;
      run1_i = 0; run0_i = 0; max1_i = 0; max0_i = 0;
      run1_e = 0; run0_e = 0; max1_e = 0; max0_e = 0;
      en8 = 1'b1;
      for (int k = 1; k <= 510; k++) begin
         tick();
         if (st_i8 == 8'd0 || st_e8 == 8'd0) zero_seen++;
         if (st_i8 == 8'd1 && first_i == 0) first_i = k;
         if (st_e8 == 8'd1 && first_e == 0) first_e = k;
         if (wr_i8) w8i++;
         if (wr_e8) w8e++;
         if (st_i8[0]) begin run1_i++; run0_i = 0; end else begin run0_i++; run1_i = 0; end
         if (st_e8[0]) begin run1_e++; run0_e = 0; end else begin run0_e++; run1_e = 0; end
         if (run1_i > max1_i) max1_i = run1_i;
         if (run0_i > max0_i) max0_i = run0_i;
         if (run1_e > max1_e) max1_e = run1_e;
         if (run0_e > max0_e) max0_e = run0_e;
      end
      en8 = 1'b0;
      check(first_i == 255, "R4 internal period", first_i, 255);
      check(first_e == 255, "R4 external period", first_e, 255);
      check(w8i == 2 && w8e == 2, "R8 wraps over two periods", w8i, 2);
      check(zero_seen == 0, "R9 never zero", zero_seen, 0);
      check(max1_i == 8 && max1_e == 8, "R10 longest ones run", max1_i, 8);
      check(max0_i == 7 && max0_e == 7, "R10 longest zeros run", max0_e, 7);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule